// File: doc/BRIEF.md
# Slit Position Tracker for Line-Scan Pixels

The block watches a serial stream of pixel samples from a linear image sensor and locates a bright slit on every scan line. Each sample is compared with a programmable threshold to form a bright/dark bit. A per-line pixel index starts at zero after each line marker. The index is caught at the first dark-to-bright transition and at the first bright-to-dark transition that follows it. From these two positions the block derives the slit's start, end, width and midpoint for the line.

A line marker (`line_start`) both opens a new line and closes the previous one. The line's results appear one clock after the marker. A capture run is armed by `cap_start`. It records the midpoint of each following closed line into a small buffer, offset from a fixed reference pixel, until the programmed number of lines has been stored. The buffer is then read back through a plain address/data port, so that slit motion can be studied over time.

Top module: `slit_edge_tracker`

## Requirements
- R1: A pixel counts as bright when `pix_data >= threshold` (unsigned), and as dark otherwise.
- R2: `line_start` resets the pixel index to 0. Each cycle with `pix_valid` high and `line_start` low gives that pixel the current index and then advances it by one. Pixels before the first `line_start` after reset are ignored.
- R3: The leading position is the index of the first bright pixel in a line whose predecessor was dark. A bright first pixel (index 0) counts as a leading edge.
- R4: The trailing position is the index of the first dark pixel after the leading edge. Any later rising or falling transitions in the same line are ignored.
- R5: One cycle after a `line_start` that closes a line, `line_done` is high for exactly one cycle. If that line had both edges, `line_ok` is 1, `lead_pos` and `trail_pos` hold the two positions, `width` = trail − lead and `centre` = (lead + trail) >> 1.
- R6: A closed line that lacks a leading edge or a trailing edge gives `line_ok` = 0. In that case `lead_pos`, `trail_pos`, `width` and `centre` keep their previous values.
- R7: After `cap_start`, the closed lines write their centre minus 1048 into buffer entries 0, 1, 2, … in order, as two's-complement values of PIX_W+1 bits. Entry `rd_addr` is shown on `rd_data` without delay.
- R8: `done` rises one cycle after the line that fills `max(num_lines,1)` entries is closed (or DEPTH entries, if fewer). After that, no entry is written until the next `cap_start`. `done` stays high until `cap_start`, which clears it.
- R9: An invalid line that is captured stores the kept (previous) centre.
- R10: The first `line_start` after reset closes no line and gives no `line_done` pulse. After reset, all outputs except `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threshold | input | DATA_W | Bright/dark decision level |
| line_start | input | 1 | Line marker: closes previous line, opens next |
| pix_valid | input | 1 | Pixel sample present |
| pix_data | input | DATA_W | Pixel sample value |
| cap_start | input | 1 | Arms a new capture run |
| num_lines | input | $clog2(DEPTH+1) | Lines to capture |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | PIX_W+1 | Captured centre minus reference, signed |
| lead_pos | output | PIX_W | Leading edge index of last good line |
| trail_pos | output | PIX_W | Trailing edge index of last good line |
| width | output | PIX_W | Slit width of last good line |
| centre | output | PIX_W | Slit midpoint of last good line |
| line_done | output | 1 | One-cycle pulse when a line result is ready |
| line_ok | output | 1 | Last closed line had both edges |
| done | output | 1 | Capture run complete |

## Verification
The embedded assertions check on every cycle the relations that hold between the outputs: a good line ends with the trailing edge past the leading edge and the midpoint and width consistent with them, an invalid line leaves the midpoint unchanged, `done` persists until re-armed, and the write index never passes the buffer. Only the directed scenarios can show that the positions match the pixels actually driven. These cover the threshold tie, a slit touching pixel 0, a second slit that must be ignored, a slit running off the end of the line, and the signed offset values read back after a capture run.

// File: rtl/slit_edge_tracker.sv
module slit_edge_tracker #(
  parameter int DATA_W   = 8,
  parameter int PIX_W    = 12,
  parameter int DEPTH    = 16,
  parameter int ZERO_REF = 1048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-1:0]            threshold,
  input  logic                         line_start,
  input  logic                         pix_valid,
  input  logic [DATA_W-1:0]            pix_data,
  input  logic                         cap_start,
  input  logic [$clog2(DEPTH+1)-1:0]   num_lines,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [PIX_W:0]               rd_data,
  output logic [PIX_W-1:0]             lead_pos,
  output logic [PIX_W-1:0]             trail_pos,
  output logic [PIX_W-1:0]             width,
  output logic [PIX_W-1:0]             centre,
  output logic                         line_done,
  output logic                         line_ok,
  output logic                         done
);
  localparam int IW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH+1);
  localparam logic [PIX_W:0] REF_V = ZERO_REF[PIX_W:0];

  logic             in_line, prev_bin, have_lead, have_trail, armed;
  logic [PIX_W-1:0] cnt, lead_lat, trail_lat;
  logic [NW-1:0]    wr_idx;
  logic [PIX_W:0]   cap_mem [DEPTH];

  wire              bin       = pix_data >= threshold;
  wire              good      = have_lead && have_trail;
  wire  [PIX_W:0]   sum_w     = {1'b0, lead_lat} + {1'b0, trail_lat};
  wire  [PIX_W-1:0] cent_next = good ? sum_w[PIX_W:1] : centre;
  wire  [PIX_W:0]   rel       = {1'b0, cent_next} - REF_V;
  wire              closing   = line_start && in_line;
  wire  [NW:0]      next_cnt  = {1'b0, wr_idx} + 1'b1;
  wire              last      = (next_cnt >= {1'b0, num_lines}) || (next_cnt == (NW+1)'(DEPTH));

  assign rd_data = cap_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_line <= 1'b0; prev_bin <= 1'b0; have_lead <= 1'b0; have_trail <= 1'b0;
      cnt <= '0; lead_lat <= '0; trail_lat <= '0;
      lead_pos <= '0; trail_pos <= '0; width <= '0; centre <= '0;
      line_done <= 1'b0; line_ok <= 1'b0;
    end else begin
      line_done <= closing;
      if (line_start) begin
        in_line <= 1'b1; prev_bin <= 1'b0; have_lead <= 1'b0; have_trail <= 1'b0;
        cnt <= '0;
        if (in_line) begin
          line_ok <= good;
          if (good) begin
            lead_pos  <= lead_lat;
            trail_pos <= trail_lat;
            width     <= trail_lat - lead_lat;
            centre    <= cent_next;
          end
        end
      end else if (pix_valid && in_line) begin
        if (bin && !prev_bin && !have_lead) begin
          have_lead <= 1'b1;
          lead_lat  <= cnt;
        end
        if (!bin && prev_bin && have_lead && !have_trail) begin
          have_trail <= 1'b1;
          trail_lat  <= cnt;
        end
        prev_bin <= bin;
        cnt      <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; done <= 1'b0; wr_idx <= '0;
    end else if (cap_start) begin
      armed <= 1'b1; done <= 1'b0; wr_idx <= '0;
    end else if (closing && armed) begin
      cap_mem[wr_idx[IW-1:0]] <= rel;
      wr_idx <= next_cnt[NW-1:0];
      if (last) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  assert_edge_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && line_ok) |-> (trail_pos > lead_pos));
  assert_mid_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && line_ok) |-> (width == trail_pos - lead_pos &&
      centre == PIX_W'(({1'b0, lead_pos} + {1'b0, trail_pos}) >> 1)));
  assert_keep_centre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !line_ok) |-> $stable(centre));
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_start) |=> done);
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (wr_idx < NW'(DEPTH)));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
endmodule

// File: tb/slit_edge_tracker_test.sv
`timescale 1ns/1ps
module slit_edge_tracker_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] threshold = 8'd100, pix_data = 0;
  logic line_start = 0, pix_valid = 0, cap_start = 0;
  logic [4:0] num_lines = 0;
  logic [3:0] rd_addr = 0;
  logic [12:0] rd_data;
  logic [11:0] lead_pos, trail_pos, width, centre;
  logic line_done, line_ok, done;
  int total = 0, bad = 0;

  slit_edge_tracker uut (.clk(clk), .rst_n(rst_n), .threshold(threshold),
    .line_start(line_start), .pix_valid(pix_valid), .pix_data(pix_data),
    .cap_start(cap_start), .num_lines(num_lines), .rd_addr(rd_addr),
    .rd_data(rd_data), .lead_pos(lead_pos), .trail_pos(trail_pos), .width(width),
    .centre(centre), .line_done(line_done), .line_ok(line_ok), .done(done));

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pixels(int n, int a1, int b1, int a2, int b2, int lvl);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1;
      pix_data = ((i >= a1 && i < b1) || (i >= a2 && i < b2)) ? lvl[7:0] : 8'd10;
      @(negedge clk);
    end
    pix_valid = 0;
  endtask

  task automatic close_line();
    line_start = 1;
    @(negedge clk);
    line_start = 0;
  endtask

  task automatic check_line(string req, int ok, int ld, int tr, int wd, int ce);
    chk({req, " line_done"}, line_done, 1);
    chk({req, " line_ok"}, line_ok, ok);
    chk({req, " lead"}, lead_pos, ld);
    chk({req, " trail"}, trail_pos, tr);
    chk({req, " width"}, width, wd);
    chk({req, " centre"}, centre, ce);
  endtask

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R10 reset line_done", line_done, 0);
    chk("R10 reset centre", centre, 0);
    send_pixels(5, 0, 5, 0, 0, 200);
    close_line();
    chk("R10 first marker no pulse", line_done, 0);
  endtask

  task automatic t_basic();
    send_pixels(40, 10, 20, 0, 0, 200);
    close_line();
    check_line("R3 R5 basic", 1, 10, 20, 10, 15);
    @(negedge clk);
    chk("R5 pulse one cycle", line_done, 0);
  endtask

  task automatic t_tie();
    send_pixels(30, 5, 8, 0, 0, 100);
    close_line();
    check_line("R1 threshold tie", 1, 5, 8, 3, 6);
  endtask

  task automatic t_second_slit();
    send_pixels(40, 3, 6, 20, 30, 200);
    close_line();
    check_line("R4 second slit ignored", 1, 3, 6, 3, 4);
  endtask

  task automatic t_from_zero();
    send_pixels(20, 0, 5, 0, 0, 200);
    close_line();
    check_line("R2 R3 bright at index 0", 1, 0, 5, 5, 2);
  endtask

  task automatic t_invalid();
    send_pixels(20, 0, 0, 0, 0, 200);
    close_line();
    check_line("R6 no edge", 0, 0, 5, 5, 2);
    send_pixels(20, 12, 20, 0, 0, 200);
    close_line();
    check_line("R6 no trailing edge", 0, 0, 5, 5, 2);
  endtask

  task automatic t_capture();
    cap_start = 1; num_lines = 3;
    @(negedge clk);
    cap_start = 0;
    send_pixels(1100, 1040, 1061, 0, 0, 200);
    close_line();
    chk("R8 not done after 1", done, 0);
    send_pixels(30, 10, 20, 0, 0, 200);
    close_line();
    chk("R8 not done after 2", done, 0);
    send_pixels(30, 0, 0, 0, 0, 200);
    close_line();
    chk("R8 done after 3", done, 1);
    send_pixels(30, 2, 4, 0, 0, 200);
    close_line();
    chk("R8 done holds", done, 1);
    rd_addr = 0; #1 chk("R7 entry 0", int'($signed(rd_data)), 2);
    rd_addr = 1; #1 chk("R7 entry 1", int'($signed(rd_data)), -1033);
    rd_addr = 2; #1 chk("R9 entry 2 kept", int'($signed(rd_data)), -1033);
    @(negedge clk);
    cap_start = 1;
    @(negedge clk);
    cap_start = 0;
    chk("R8 cap_start clears done", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_second_slit();
    t_from_zero();
    t_invalid();
    t_capture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule